// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block decides, every cycle, which hardware thread the commit stage of a multithreaded out-of-order core retires from. For each thread it sees whether the thread is active, whether the instruction at the head of that thread's reorder buffer is ready to commit, and that head instruction's 16-bit sequence number. A thread is eligible when it is both active and head-ready. The block reports one eligible thread and a valid flag. The choice is combinational from the current inputs and a small amount of registered state.

Three policies can be selected at run time. The greedy policy stays with one thread for as long as it can. The rotating policy shares commit bandwidth fairly. The age policy favours the thread whose head instruction is oldest. A single-thread mode input pins the choice to thread 0.

The block does not hold instructions, retire them or count commit width. It only names the thread.

A two-state FSM carries the greedy hold:
- **SEEK**: no thread is held.
- **HOLD**: the thread held in `hold_q` is the greedy owner.

Its transitions are:
- **latch** (SEEK→HOLD): a greedy grant is made.
- **keep** (HOLD→HOLD): the held thread is still eligible.
- **retarget** (HOLD→HOLD): the held thread has dropped out and another eligible thread is taken.
- **release** (HOLD→SEEK or SEEK→SEEK): one of the following applies:
  - no thread is eligible;
  - the policy is not greedy;
  - single-thread mode is on.

A separate rotation pointer serves the rotating policy.

Top module: `commit_thread_sel`

## Requirements
- R1: After reset the FSM is in SEEK and the rotation pointer is 0, so the first rotating grant with all threads eligible goes to thread 0.
- R2: Outside single-thread mode, `sel_vld` is 1 exactly when some thread has both `act_mask` and `head_rdy` set, and a valid `sel_tid` always names such a thread. When `sel_vld` is 0, `sel_tid` is 0.
- R3: When `single_mode` is 1, `sel_tid` is 0 and `sel_vld` equals `act_mask[0] & head_rdy[0]`. Other threads are ignored, the rotation pointer is left unchanged and the FSM returns to SEEK.
- R4: Under the greedy policy (`policy` = 2'b00, and 2'b11 behaves identically) with no held thread eligible, the lowest-numbered eligible thread is chosen.
- R5: Under the greedy policy, a thread granted in one cycle is granted again in the next cycle while it stays eligible, even if a lower-numbered thread becomes eligible. Leaving the greedy policy drops the hold.
- R6: Under the rotating policy (`policy` = 2'b01), the scan starts at the rotation pointer and takes the first eligible thread in increasing order with wrap. After a grant, the pointer becomes the granted thread plus one, modulo the thread count.
- R7: A cycle without a grant leaves the rotation pointer unchanged.
- R8: Under the age policy (`policy` = 2'b10), the eligible thread with the smallest `head_seq` is chosen. Thread i's number is `head_seq[i*16 +: 16]`, compared unsigned.
- R9: Under the age policy, equal sequence numbers resolve to the lower thread ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_mode | input | 1 | Pin selection to thread 0 |
| policy | input | 2 | 00 greedy, 01 rotating, 10 age, 11 greedy |
| act_mask | input | NTHR | Per-thread active flag |
| head_rdy | input | NTHR | Per-thread head-ready flag |
| head_seq | input | NTHR*SEQW | Packed head sequence numbers, thread 0 in the low bits |
| sel_tid | output | TIDW | Chosen thread |
| sel_vld | output | 1 | A thread was chosen |

## Verification
A rotation pointer that has slipped is not visible while only one thread is eligible. It shows on the first rotating cycle with two or more eligible threads, as a grant to the wrong thread in that same cycle. A wrong hold register or FSM state shows when a lower-numbered thread becomes eligible while the held thread is still ready: the grant jumps away from the held thread, or sticks to a thread that has dropped out, one cycle after the bad update. The bench therefore builds such overlapping eligibility patterns deliberately. It also mixes policies and single-thread mode between them, so that stale state left by one mode is exercised by the next.

// File: rtl/cts_pkg.sv
package cts_pkg;
    typedef enum logic [1:0] {
        POL_GREEDY = 2'b00,
        POL_ROTATE = 2'b01,
        POL_AGE    = 2'b10,
        POL_SPARE  = 2'b11
    } pol_e;

    typedef enum logic [0:0] {
        ST_SEEK = 1'b0,
        ST_HOLD = 1'b1
    } hold_st_e;
endpackage

// File: rtl/cts_low_pick.sv
module cts_low_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Walk from the top down so the lowest set index is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cts_rot_pick.sv
module cts_rot_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [IW:0] pos;

    // Scan N positions starting at ptr, wrapping past the top thread.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = '0;
        for (int k = 0; k < N; k++) begin
            pos = {1'b0, ptr} + (IW + 1)'(k);
            if (pos >= (IW + 1)'(N)) begin
                pos = pos - (IW + 1)'(N);
            end
            if (!found && req[pos[IW-1:0]]) begin
                found = 1'b1;
                idx   = pos[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/cts_age_pick.sv
module cts_age_pick #(
    parameter int N    = 4,
    parameter int SEQW = 16,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]      req,
    input  logic [N*SEQW-1:0] seq,
    output logic              found,
    output logic [IW-1:0]     idx
);
    logic [SEQW-1:0] best;

    // Strict less-than keeps the earlier (lower) thread on a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || seq[i*SEQW +: SEQW] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = seq[i*SEQW +: SEQW];
            end
        end
    end
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
    import cts_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int SEQW = 16,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 single_mode,
    input  logic [1:0]           policy,
    input  logic [NTHR-1:0]      act_mask,
    input  logic [NTHR-1:0]      head_rdy,
    input  logic [NTHR*SEQW-1:0] head_seq,
    output logic [TIDW-1:0]      sel_tid,
    output logic                 sel_vld
);
    localparam logic [TIDW-1:0] LAST_TID = TIDW'(NTHR - 1);

    pol_e            pol;
    hold_st_e        st_q, st_d;
    logic [TIDW-1:0] hold_q, hold_d;
    logic [TIDW-1:0] rr_q, rr_d;
    logic [NTHR-1:0] elig;
    logic            hold_ok;

    logic            lo_f, rr_f, ag_f;
    logic [TIDW-1:0] lo_i, rr_i, ag_i;

    assign pol     = pol_e'(policy);
    assign elig    = act_mask & head_rdy;
    assign hold_ok = (st_q == ST_HOLD) && elig[hold_q];

    cts_low_pick #(.N(NTHR)) u_low (
        .req(elig), .found(lo_f), .idx(lo_i)
    );

    cts_rot_pick #(.N(NTHR)) u_rot (
        .req(elig), .ptr(rr_q), .found(rr_f), .idx(rr_i)
    );

    cts_age_pick #(.N(NTHR), .SEQW(SEQW)) u_age (
        .req(elig), .seq(head_seq), .found(ag_f), .idx(ag_i)
    );

    // Output process: grant for the current cycle.
    always_comb begin
        sel_tid = '0;
        sel_vld = 1'b0;
        if (single_mode) begin
            sel_vld = elig[0];
        end else begin
            unique case (pol)
                POL_GREEDY, POL_SPARE: begin
                    if (hold_ok) begin
                        sel_tid = hold_q;
                        sel_vld = 1'b1;
                    end else begin
                        sel_tid = lo_i;
                        sel_vld = lo_f;
                    end
                end
                POL_ROTATE: begin
                    sel_tid = rr_i;
                    sel_vld = rr_f;
                end
                POL_AGE: begin
                    sel_tid = ag_i;
                    sel_vld = ag_f;
                end
                default: begin
                    sel_tid = '0;
                    sel_vld = 1'b0;
                end
            endcase
        end
    end

    // Next-state process: hold FSM and rotation pointer.
    always_comb begin
        st_d   = st_q;
        hold_d = hold_q;
        rr_d   = rr_q;
        if (!single_mode && pol == POL_ROTATE && sel_vld) begin
            rr_d = (sel_tid == LAST_TID) ? '0 : sel_tid + 1'b1;
        end
        unique case (st_q)
            ST_SEEK: begin
                if (!single_mode && (pol == POL_GREEDY || pol == POL_SPARE) && sel_vld) begin
                    st_d   = ST_HOLD;          // latch
                    hold_d = sel_tid;
                end else begin
                    st_d   = ST_SEEK;          // release (stay idle)
                end
            end
            ST_HOLD: begin
                if (single_mode || !(pol == POL_GREEDY || pol == POL_SPARE) || !sel_vld) begin
                    st_d   = ST_SEEK;          // release
                end else begin
                    st_d   = ST_HOLD;          // keep or retarget
                    hold_d = sel_tid;
                end
            end
            default: st_d = ST_SEEK;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_SEEK;
            hold_q <= '0;
            rr_q   <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            rr_q   <= rr_d;
        end
    end

    // ---------------- assertions ----------------
    AST_VALID_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode && sel_vld) |-> (act_mask[sel_tid] && head_rdy[sel_tid])); // R2

    AST_VALID_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        !single_mode |-> (sel_vld == (|(act_mask & head_rdy)))); // R2

    AST_SINGLE_T0: assert property (@(posedge clk) disable iff (!rst_n)
        single_mode |-> (sel_tid == '0 && sel_vld == (act_mask[0] & head_rdy[0]))); // R3

    AST_GREEDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode && policy == 2'b00 && sel_vld) ##1
        (!single_mode && policy == 2'b00 && act_mask[$past(sel_tid)] && head_rdy[$past(sel_tid)])
        |-> sel_tid == $past(sel_tid)); // R5

    AST_ROT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode && pol == POL_ROTATE && sel_vld) |=>
        rr_q == (($past(sel_tid) == LAST_TID) ? '0 : $past(sel_tid) + 1'b1)); // R6

    AST_ROT_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_vld |=> $stable(rr_q)); // R7

    generate
        for (genvar g = 0; g < NTHR; g++) begin : g_age_chk
            AST_AGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
                (!single_mode && pol == POL_AGE && sel_vld && act_mask[g] && head_rdy[g])
                |-> (head_seq[sel_tid*SEQW +: SEQW] <= head_seq[g*SEQW +: SEQW])); // R8
        end
    endgenerate
endmodule

// File: tb/tb_commit_thread_sel.sv
`timescale 1ns/1ps
module tb_commit_thread_sel;
    localparam int N = 4;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         single_mode = 1'b0;
    logic [1:0]   policy = 2'b01;
    logic [N-1:0] act_mask = '0;
    logic [N-1:0] head_rdy = '0;
    logic [N*W-1:0] head_seq = '0;
    logic [1:0]   sel_tid;
    logic         sel_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int  m_rr = 0;
    bit  m_hold_v = 1'b0;
    int  m_hold = 0;

    always #4 clk = ~clk;

    commit_thread_sel #(.NTHR(N), .SEQW(W)) dut (
        .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .policy(policy),
        .act_mask(act_mask), .head_rdy(head_rdy), .head_seq(head_seq),
        .sel_tid(sel_tid), .sel_vld(sel_vld)
    );

    function automatic logic [N*W-1:0] pack(input int s0, input int s1, input int s2, input int s3);
        return {W'(s3), W'(s2), W'(s1), W'(s0)};
    endfunction

    task automatic check(input string tag, input int act_t, input int exp_t, input bit act_v, input bit exp_v);
        checks++;
        if (act_t != exp_t || act_v != exp_v) begin
            errors++;
            $display("FAIL %s: tid=%0d vld=%0d expected tid=%0d vld=%0d", tag, act_t, act_v, exp_t, exp_v);
        end
    endtask

    // Drive one cycle, compare against model, then advance model state.
    task automatic step(input string tag, input bit sm, input logic [1:0] pol,
                        input logic [N-1:0] act, input logic [N-1:0] rdy, input logic [N*W-1:0] sq);
        logic [N-1:0] el;
        int  et;
        bit  ev;
        int  best;
        @(negedge clk);
        single_mode = sm; policy = pol; act_mask = act; head_rdy = rdy; head_seq = sq;
        el = act & rdy;
        et = 0; ev = 1'b0;
        if (sm) begin
            ev = el[0];
        end else if (pol == 2'b01) begin
            for (int k = 0; k < N; k++) begin
                if (!ev && el[(m_rr + k) % N]) begin ev = 1'b1; et = (m_rr + k) % N; end
            end
        end else if (pol == 2'b10) begin
            best = 0;
            for (int i = 0; i < N; i++) begin
                if (el[i] && (!ev || int'(sq[i*W +: W]) < best)) begin
                    ev = 1'b1; et = i; best = int'(sq[i*W +: W]);
                end
            end
        end else begin
            if (m_hold_v && el[m_hold]) begin
                ev = 1'b1; et = m_hold;
            end else begin
                for (int i = N - 1; i >= 0; i--) if (el[i]) begin ev = 1'b1; et = i; end
            end
        end
        #1;
        check(tag, int'(sel_tid), et, sel_vld, ev);
        if (!sm && pol == 2'b01 && ev) m_rr = (et + 1) % N;
        if (!sm && (pol == 2'b00 || pol == 2'b11) && ev) begin
            m_hold_v = 1'b1; m_hold = et;
        end else begin
            m_hold_v = 1'b0;
        end
    endtask

    task automatic t_reset();
        // R1: rotating grant with everyone eligible right after reset -> thread 0
        step("R1 reset pointer", 1'b0, 2'b01, 4'hF, 4'hF, '0);
        check("R1 explicit tid0", int'(sel_tid), 0, sel_vld, 1'b1);
    endtask

    task automatic t_single();
        step("R3 single idle", 1'b1, 2'b01, 4'hF, 4'hE, '0);
        check("R3 single explicit", int'(sel_tid), 0, sel_vld, 1'b0);
        step("R3 single t0 ready", 1'b1, 2'b00, 4'hF, 4'hF, '0);
        // R3: pointer untouched -> rotation continues from thread 1
        step("R3 pointer kept", 1'b0, 2'b01, 4'hF, 4'hF, '0);
        check("R3 pointer explicit", int'(sel_tid), 1, sel_vld, 1'b1);
    endtask

    task automatic t_greedy();
        step("R4 lowest", 1'b0, 2'b00, 4'hF, 4'h6, '0);
        check("R4 explicit", int'(sel_tid), 1, sel_vld, 1'b1);
        step("R5 hold vs lower", 1'b0, 2'b00, 4'hF, 4'h7, '0);
        check("R5 explicit", int'(sel_tid), 1, sel_vld, 1'b1);
        step("R5 retarget", 1'b0, 2'b00, 4'hF, 4'h5, '0);
        step("R2 none eligible", 1'b0, 2'b00, 4'hF, 4'h0, '0);
        check("R2 none explicit", int'(sel_tid), 0, sel_vld, 1'b0);
        step("R4 top only", 1'b0, 2'b11, 4'hF, 4'h8, '0);
        step("R5 spare code holds", 1'b0, 2'b11, 4'hF, 4'h9, '0);
        check("R5 spare explicit", int'(sel_tid), 3, sel_vld, 1'b1);
        step("R5 leave greedy", 1'b0, 2'b10, 4'hF, 4'h9, pack(5, 5, 5, 5));
        step("R5 hold dropped", 1'b0, 2'b00, 4'hF, 4'h9, '0);
        check("R5 dropped explicit", int'(sel_tid), 0, sel_vld, 1'b1);
    endtask

    task automatic t_rotate();
        for (int r = 0; r < 6; r++) step("R6 full rotation", 1'b0, 2'b01, 4'hF, 4'hF, '0);
        step("R6 skip gaps", 1'b0, 2'b01, 4'hF, 4'h9, '0);
        step("R7 empty cycle", 1'b0, 2'b01, 4'hF, 4'h0, '0);
        step("R7 pointer held", 1'b0, 2'b01, 4'hF, 4'hF, '0);
        step("R2 inactive ignored", 1'b0, 2'b01, 4'h5, 4'hF, '0);
        step("R2 inactive ignored 2", 1'b0, 2'b01, 4'h5, 4'hF, '0);
    endtask

    task automatic t_age();
        step("R8 oldest", 1'b0, 2'b10, 4'hF, 4'hF, pack(300, 40, 900, 41));
        check("R8 explicit", int'(sel_tid), 1, sel_vld, 1'b1);
        step("R8 oldest not ready", 1'b0, 2'b10, 4'hF, 4'hD, pack(300, 40, 900, 41));
        check("R8 skip explicit", int'(sel_tid), 3, sel_vld, 1'b1);
        step("R9 tie", 1'b0, 2'b10, 4'hF, 4'hE, pack(7, 65535, 12, 12));
        check("R9 explicit", int'(sel_tid), 2, sel_vld, 1'b1);
        step("R8 inactive oldest", 1'b0, 2'b10, 4'hE, 4'hF, pack(0, 9, 8, 65535));
    endtask

    task automatic t_mixed();
        logic [15:0] lf = 16'hACE1;
        for (int c = 0; c < 400; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R2 mixed", (lf[15:12] == 4'h0), lf[1:0], lf[5:2] | 4'h3, lf[9:6],
                 pack(int'(lf[11:8]), int'(lf[3:0]), int'(lf[7:4]), int'(lf[15:12])));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_greedy();
        t_rotate();
        t_age();
        t_mixed();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule